// File: doc/BRIEF.md
# Dual-Mode Nibble Bus Target Header Decoder

This block is the receiving front end of a memory target on a 4-bit multiplexed bus. It samples a frame strobe and a nibble bus on every rising clock edge, finds the start of each bus cycle, collects the header nibbles that follow, and decides whether the cycle is addressed to this device. When it is, the block raises a one-cycle hit pulse and presents the read/write direction and the full 32-bit address. Data transfer, turnaround, sync responses and the storage array are handled by other blocks.

The block has two header formats. The operating format is picked by a configuration input, and that input is sampled only while reset is held. In the hub format, a 4-bit device number carried in the header is compared with a 4-bit strap. In the pin-count format, the two upper strap bits are compared, inverted, with address bits 21:20, and the two lower strap bits play no part.

Top module: `nibble_target_decoder`

## Requirements
- R1: A cycle begins when `frame_n` is sampled low with a valid start nibble on `bus_nib`. The nine nibbles sampled on the following edges while `frame_n` is high form the header.
- R2: If `frame_n` is sampled low while a header is being collected, the partial header is discarded and start detection begins again on that same edge. When `frame_n` stays low for several edges, only the nibble on the last of those edges counts as the start.
- R3: A start nibble that the active format does not recognise makes the decoder ignore the cycle. There is no hit until the next valid start.
- R4: The format select `mode_cfg` (0 = hub format, 1 = pin-count format) is captured on every clock edge while `rst` is high. Changes to it while `rst` is low have no effect.
- R5: Hub format: the start nibble is 4'b1101 for a read or 4'b1110 for a write. It is followed by a device-number nibble, then seven address nibbles most significant first, then a size nibble that is ignored. The reported address is the 28-bit value, zero-extended to 32 bits. `hit_write` is 1 for the write start code.
- R6: Hub format: a hit happens only when the device-number nibble equals `strap_id[3:0]`. The value 4'b0000 (the boot device) matches like any other value.
- R7: Pin-count format: the start nibble is 4'b0000, followed by a cycle-type nibble and then eight address nibbles most significant first. `hit_write` equals bit 1 of the cycle-type nibble.
- R8: Pin-count format: a hit happens only when `strap_id[3]` equals the inverse of address bit 21 and `strap_id[2]` equals the inverse of address bit 20. `strap_id[1:0]` has no effect.
- R9: On a match, `hit` is high for exactly the one cycle after the edge that samples the final header nibble. `hit_addr` and `hit_write` are loaded on that edge and hold their values until the next hit.
- R10: A completed header that fails the device selection produces no hit and leaves `hit_addr` and `hit_write` unchanged.
- R11: A synchronous active-high `rst` abandons any header in progress and clears `hit`, `hit_write` and `hit_addr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_cfg | input | 1 | Format select, captured only during reset (0 hub, 1 pin-count) |
| frame_n | input | 1 | Active-low frame strobe |
| bus_nib | input | 4 | Multiplexed nibble bus |
| strap_id | input | 4 | Board strap giving this device's identity |
| hit | output | 1 | One-cycle pulse: header complete and addressed here |
| hit_write | output | 1 | Direction of the last hit cycle (1 = write) |
| hit_addr | output | 32 | Address of the last hit cycle |

## Verification
The start nibble is sampled on the edge where `frame_n` is low. The nine header nibbles are sampled on the following nine edges. `hit`, `hit_write` and `hit_addr` change on the edge that samples the ninth nibble, so they are due one register stage after the last nibble and are first visible in the half-cycle that follows. The bench drives inputs on falling edges and updates its behavioural model on the same rising edge as the design. It compares all three outputs on every falling edge, so each result is read exactly half a cycle after the edge that produced it. Directed cases also count observed hit pulses a few idle cycles after each header, which catches missing and spurious pulses alike.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
   localparam int NIB_W = 4;

   localparam logic [NIB_W-1:0] HUB_START_RD = 4'b1101;
   localparam logic [NIB_W-1:0] HUB_START_WR = 4'b1110;
   localparam logic [NIB_W-1:0] PIN_START    = 4'b0000;

   typedef enum logic {
      FMT_HUB = 1'b0,
      FMT_PIN = 1'b1
   } fmt_e;

   typedef enum logic {
      HS_IDLE = 1'b0,
      HS_HDR  = 1'b1
   } hdr_state_e;
endpackage

// File: rtl/nbd_frame_ctrl.sv
module nbd_frame_ctrl
   import nbd_pkg::*;
#(
   parameter int HDR_NIBS = 9,
   localparam int CNT_W   = $clog2(HDR_NIBS)
) (
   input  logic             clk,
   input  logic             rst,
   input  fmt_e             fmt,
   input  logic             frame_n,
   input  logic [NIB_W-1:0] nib,
   output logic             take,
   output logic [CNT_W-1:0] idx,
   output logic             done,
   output logic             start_wr
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_NIBS - 1);

   hdr_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             wr_q;
   logic             valid_start;

   always_comb begin
      if (fmt == FMT_PIN) valid_start = (nib == PIN_START);
      else                valid_start = (nib == HUB_START_RD) || (nib == HUB_START_WR);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= HS_IDLE;
         cnt   <= '0;
         wr_q  <= 1'b0;
      end else if (!frame_n) begin
         state <= valid_start ? HS_HDR : HS_IDLE;
         cnt   <= '0;
         wr_q  <= (fmt == FMT_HUB) && (nib == HUB_START_WR);
      end else if (state == HS_HDR) begin
         if (cnt == LAST_IDX) begin
            state <= HS_IDLE;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign take     = (state == HS_HDR) && frame_n;
   assign idx      = cnt;
   assign done     = take && (cnt == LAST_IDX);
   assign start_wr = wr_q;
endmodule

// File: rtl/nbd_hdr_capture.sv
module nbd_hdr_capture
   import nbd_pkg::*;
#(
   parameter int ADDR_NIBS = 8,
   parameter int HDR_NIBS  = 9,
   localparam int ADDR_W   = ADDR_NIBS * NIB_W,
   localparam int CNT_W    = $clog2(HDR_NIBS)
) (
   input  logic              clk,
   input  logic              rst,
   input  fmt_e              fmt,
   input  logic              frame_n,
   input  logic [NIB_W-1:0]  nib,
   input  logic              take,
   input  logic [CNT_W-1:0]  idx,
   output logic [NIB_W-1:0]  tag,
   output logic [ADDR_W-1:0] addr_full
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_NIBS - 1);

   logic [ADDR_W-1:0] shreg;
   logic              shift_en;

   assign shift_en = take && (idx != '0) && ((fmt == FMT_PIN) || (idx != LAST_IDX));

   always_ff @(posedge clk) begin
      if (rst) begin
         tag   <= '0;
         shreg <= '0;
      end else if (!frame_n) begin
         tag   <= '0;
         shreg <= '0;
      end else if (take && (idx == '0)) begin
         tag <= nib;
      end else if (shift_en) begin
         shreg <= {shreg[ADDR_W-NIB_W-1:0], nib};
      end
   end

   // Pin-count: last address nibble arrives in the completing cycle.
   // Hub: completing cycle carries the size nibble, address already complete.
   always_comb begin
      if (fmt == FMT_PIN) addr_full = {shreg[ADDR_W-NIB_W-1:0], nib};
      else                addr_full = shreg;
   end
endmodule

// File: rtl/nbd_id_match.sv
module nbd_id_match
   import nbd_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  fmt_e             fmt,
   input  logic [NIB_W-1:0] tag,
   input  logic [SEL_W-1:0] addr_sel,
   input  logic [NIB_W-1:0] strap,
   output logic             match
);
   logic [SEL_W-1:0] bit_ok;

   // Pin-count compare: strap bit low selects address bit high.
   for (genvar i = 0; i < SEL_W; i++) begin : g_sel
      assign bit_ok[i] = (strap[NIB_W-SEL_W+i] != addr_sel[i]);
   end

   always_comb begin
      if (fmt == FMT_PIN) match = &bit_ok;
      else                match = (tag == strap);
   end
endmodule

// File: rtl/nibble_target_decoder.sv
module nibble_target_decoder
   import nbd_pkg::*;
#(
   parameter int ADDR_NIBS = 8,
   parameter int HUB_ADDR_NIBS = 7,
   parameter int SEL_LSB = 20,
   parameter int SEL_W = 2,
   localparam int ADDR_W = ADDR_NIBS * NIB_W,
   localparam int HDR_NIBS = ADDR_NIBS + 1,
   localparam int CNT_W = $clog2(HDR_NIBS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_cfg,
   input  logic              frame_n,
   input  logic [NIB_W-1:0]  bus_nib,
   input  logic [NIB_W-1:0]  strap_id,
   output logic              hit,
   output logic              hit_write,
   output logic [ADDR_W-1:0] hit_addr
);
   if (HUB_ADDR_NIBS + 2 != HDR_NIBS) begin : g_bad_hub
      $error("hub header must be as long as pin-count header");
   end
   if (SEL_W > NIB_W || SEL_W < 1) begin : g_bad_selw
      $error("SEL_W out of range");
   end
   if (SEL_LSB + SEL_W > ADDR_W) begin : g_bad_sel
      $error("select bits outside address");
   end

   fmt_e              mode_q;
   logic              take, done, start_wr, match;
   logic [CNT_W-1:0]  idx;
   logic [NIB_W-1:0]  tag;
   logic [ADDR_W-1:0] addr_full;

   always_ff @(posedge clk) begin
      if (rst) mode_q <= fmt_e'(mode_cfg);
   end

   nbd_frame_ctrl #(.HDR_NIBS(HDR_NIBS)) u_ctrl (
      .clk(clk), .rst(rst), .fmt(mode_q), .frame_n(frame_n), .nib(bus_nib),
      .take(take), .idx(idx), .done(done), .start_wr(start_wr)
   );

   nbd_hdr_capture #(.ADDR_NIBS(ADDR_NIBS), .HDR_NIBS(HDR_NIBS)) u_cap (
      .clk(clk), .rst(rst), .fmt(mode_q), .frame_n(frame_n), .nib(bus_nib),
      .take(take), .idx(idx), .tag(tag), .addr_full(addr_full)
   );

   nbd_id_match #(.SEL_W(SEL_W)) u_match (
      .fmt(mode_q), .tag(tag), .addr_sel(addr_full[SEL_LSB +: SEL_W]),
      .strap(strap_id), .match(match)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         hit       <= 1'b0;
         hit_write <= 1'b0;
         hit_addr  <= '0;
      end else begin
         hit <= done && match;
         if (done && match) begin
            hit_addr  <= addr_full;
            hit_write <= (mode_q == FMT_PIN) ? tag[1] : start_wr;
         end
      end
   end
endmodule

module nbd_checker
   import nbd_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic        frame_n,
   input logic [3:0]  strap_id,
   input fmt_e        mode_q,
   input logic        hit,
   input logic        hit_write,
   input logic [31:0] hit_addr
);
   p_hit_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      hit |=> !hit);

   p_hit_after_frame_high_r2: assert property (@(posedge clk) disable iff (rst)
      hit |-> $past(frame_n));

   p_mode_frozen_r4: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> $stable(mode_q));

   p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!hit && !hit_write && hit_addr == 32'h0));

   p_hub_addr_width_r5: assert property (@(posedge clk) disable iff (rst)
      (hit && mode_q == FMT_HUB) |-> (hit_addr[31:28] == 4'h0));

   p_pin_select_r8: assert property (@(posedge clk) disable iff (rst)
      (hit && mode_q == FMT_PIN) |-> (hit_addr[21:20] == ~$past(strap_id[3:2])));
endmodule

bind nibble_target_decoder nbd_checker u_nbd_checker (
   .clk(clk), .rst(rst), .frame_n(frame_n), .strap_id(strap_id),
   .mode_q(mode_q), .hit(hit), .hit_write(hit_write), .hit_addr(hit_addr)
);

// File: tb/nibble_target_decoder_bench.sv
module nibble_target_decoder_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mode_cfg = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  bus_nib = 4'h0;
   logic [3:0]  strap_id = 4'b0101;
   logic        hit, hit_write;
   logic [31:0] hit_addr;

   int checks = 0;
   int errors = 0;
   int dut_hits = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nibble_target_decoder u_nibble_target_decoder (
      .clk(clk), .rst(rst), .mode_cfg(mode_cfg), .frame_n(frame_n),
      .bus_nib(bus_nib), .strap_id(strap_id),
      .hit(hit), .hit_write(hit_write), .hit_addr(hit_addr)
   );

   // Behavioural reference model
   bit          m_pin;
   bit          m_busy;
   bit          m_swr;
   logic [3:0]  m_q[$];
   bit          e_hit;
   bit          e_wr;
   logic [31:0] e_addr;

   always @(posedge clk) begin
      if (rst) begin
         m_pin = mode_cfg; m_busy = 0; m_q.delete();
         e_hit = 0; e_wr = 0; e_addr = 0;
      end else begin
         e_hit = 0;
         if (!frame_n) begin
            m_q.delete();
            m_busy = m_pin ? (bus_nib == 4'h0) : (bus_nib == 4'hD || bus_nib == 4'hE);
            m_swr  = (bus_nib == 4'hE);
         end else if (m_busy) begin
            m_q.push_back(bus_nib);
            if (m_q.size() == 9) begin
               logic [31:0] a;
               bit sel;
               m_busy = 0;
               a = 0;
               if (m_pin) begin
                  for (int i = 1; i <= 8; i++) a = (a << 4) | 32'(m_q[i]);
                  sel = (strap_id[3] == !a[21]) && (strap_id[2] == !a[20]);
               end else begin
                  for (int i = 1; i <= 7; i++) a = (a << 4) | 32'(m_q[i]);
                  sel = (m_q[0] == strap_id);
               end
               if (sel) begin
                  e_hit = 1; e_addr = a;
                  e_wr = m_pin ? m_q[0][1] : m_swr;
               end
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison, half a cycle after each update edge
   always @(negedge clk) begin
      if (hit) dut_hits++;
      chk(hit == e_hit, "R9 hit", 32'(hit), 32'(e_hit));
      chk(hit_write == e_wr, "R9 hit_write", 32'(hit_write), 32'(e_wr));
      chk(hit_addr == e_addr, "R9 hit_addr", hit_addr, e_addr);
   end

   task automatic drive(input logic f, input logic [3:0] n);
      @(negedge clk);
      frame_n = f; bus_nib = n;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b1, 4'h0);
   endtask

   task automatic do_reset(input logic m);
      @(negedge clk);
      rst = 1'b1; mode_cfg = m; frame_n = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic send(input logic [3:0] start, input logic [35:0] hdr);
      drive(1'b0, start);
      for (int i = 0; i < 9; i++) drive(1'b1, hdr[35 - 4*i -: 4]);
   endtask

   task automatic expect_hits(input int base, input int exp, input string req);
      idle(3);
      chk(dut_hits - base == exp, req, 32'(dut_hits - base), 32'(exp));
   endtask

   int base;

   initial begin
      do_reset(1'b0);
      @(negedge clk);
      chk(hit == 0 && hit_write == 0 && hit_addr == 0, "R11 reset state", hit_addr, 0);

      // R5/R6: hub read to own device number
      base = dut_hits; send(4'hD, {4'b0101, 28'h0ABCDEF, 4'h3});
      expect_hits(base, 1, "R5 R6 hub read hit");
      chk(hit_addr == 32'h0ABCDEF && !hit_write, "R5 hub read fields", hit_addr, 32'h0ABCDEF);

      // R5: hub write
      base = dut_hits; send(4'hE, {4'b0101, 28'h1234567, 4'h0});
      expect_hits(base, 1, "R5 hub write hit");
      chk(hit_write == 1, "R5 hub write flag", 32'(hit_write), 1);

      // R10/R6: wrong device number, fields held
      base = dut_hits; send(4'hD, {4'b0100, 28'h7654321, 4'h0});
      expect_hits(base, 0, "R10 R6 hub mismatch");
      chk(hit_addr == 32'h1234567, "R10 fields held", hit_addr, 32'h1234567);

      // R3: unknown start code in hub format
      base = dut_hits; send(4'h0, {4'b0101, 28'h0000001, 4'h0});
      expect_hits(base, 0, "R3 bad start hub");

      // R2: abort part way, then restart on same edge
      base = dut_hits;
      drive(1'b0, 4'hD);
      drive(1'b1, 4'b0101); drive(1'b1, 4'h9); drive(1'b1, 4'h9);
      send(4'hD, {4'b0101, 28'h0C0FFEE, 4'h0});
      expect_hits(base, 1, "R2 abort and restart");
      chk(hit_addr == 32'h0C0FFEE, "R2 restarted address", hit_addr, 32'h0C0FFEE);

      // R2: multiple frame-low edges, last start nibble counts
      base = dut_hits;
      drive(1'b0, 4'h0); drive(1'b0, 4'h3);
      send(4'hE, {4'b0101, 28'h0000ABC, 4'h0});
      expect_hits(base, 1, "R2 repeated frame low");

      // R2: abort by frame low with invalid code leaves decoder idle
      base = dut_hits;
      drive(1'b0, 4'hD); drive(1'b1, 4'b0101); drive(1'b0, 4'h7);
      for (int i = 0; i < 8; i++) drive(1'b1, 4'h1);
      expect_hits(base, 0, "R2 abort to idle");

      // R4: format select ignored outside reset
      mode_cfg = 1'b1;
      base = dut_hits; send(4'hD, {4'b0101, 28'h0000042, 4'h0});
      expect_hits(base, 1, "R4 mode frozen hub");

      // R6: boot device number 0000
      strap_id = 4'b0000;
      base = dut_hits; send(4'hD, {4'b0000, 28'h0FFFFF0, 4'h0});
      expect_hits(base, 1, "R6 boot device");

      // R11: reset mid-header clears outputs
      drive(1'b0, 4'hD); drive(1'b1, 4'h0); drive(1'b1, 4'h5);
      do_reset(1'b1);
      @(negedge clk);
      chk(hit == 0 && hit_write == 0 && hit_addr == 0, "R11 mid-header reset", hit_addr, 0);

      // R7/R8: pin-count format, strap 01xx selects addr[21:20]=10
      strap_id = 4'b0111;
      base = dut_hits; send(4'h0, {4'b0000, 32'hFFA12345});
      expect_hits(base, 1, "R7 R8 pin read hit");
      chk(hit_addr == 32'hFFA12345 && !hit_write, "R7 pin read fields", hit_addr, 32'hFFA12345);

      base = dut_hits; send(4'h0, {4'b0010, 32'h00A00010});
      expect_hits(base, 1, "R7 pin write hit");
      chk(hit_write == 1, "R7 pin write flag", 32'(hit_write), 1);

      // R8/R10: wrong upper address bits
      base = dut_hits; send(4'h0, {4'b0000, 32'hFF912345});
      expect_hits(base, 0, "R8 R10 pin mismatch");
      chk(hit_addr == 32'h00A00010, "R10 pin fields held", hit_addr, 32'h00A00010);

      // R8: lower strap bits ignored
      strap_id = 4'b0100;
      base = dut_hits; send(4'h0, {4'b0000, 32'h12E00000});
      expect_hits(base, 1, "R8 low straps ignored");

      // R8: all-ones straps select address bits 00
      strap_id = 4'b1100;
      base = dut_hits; send(4'h0, {4'b0000, 32'h000C0000});
      expect_hits(base, 1, "R8 strap 11 selects 00");

      // R3: hub start code in pin-count format
      base = dut_hits; send(4'hD, {4'b0000, 32'h000C0000});
      expect_hits(base, 0, "R3 bad start pin");

      // R4: format select ignored outside reset (pin-count kept)
      mode_cfg = 1'b0;
      base = dut_hits; send(4'h0, {4'b0000, 32'h00000000});
      expect_hits(base, 1, "R4 mode frozen pin");

      // R1: back-to-back headers each decoded
      base = dut_hits;
      send(4'h0, {4'b0000, 32'h00011111});
      send(4'h0, {4'b0010, 32'h00022222});
      expect_hits(base, 2, "R1 back-to-back");

      idle(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule